// File: doc/BRIEF.md
# Operand-Gated Multiplier with Domain Sleep Control

This block is an unsigned 32x32-bit multiplier whose partial-product array is cut into three power domains. The low domain forms the product of the two lower operand halves and never sleeps. The middle domain forms the two cross terms (upper half of one operand times lower half of the other). The high domain forms the product of the two upper halves. Zero detectors on the upper halves of both operands decide which gateable domains a request actually needs, and a small controller per domain switches that domain off when it has gone unused for long enough.

A domain that has been switched off must be woken before a request that depends on it is accepted. The wake-up takes a fixed number of cycles, during which the block holds its ready output low. Requests that need no sleeping domain pass straight through. The product is registered and appears with a one-cycle valid pulse on the cycle after acceptance. A sleeping domain drives zeros into the result adder, so the result is exact in every power mode. The power switches are modelled only as the sleep outputs and the wake delay.

Top module: `opgate_mul`

## Requirements
- R1: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high; at the next edge `out_valid` rises for exactly one cycle and `product` holds the unsigned 64-bit product of the accepted `op_a` and `op_b`.
- R2: While reset is held, and on any cycle after a cycle with no accepted request, `out_valid` is low; leaving reset, both sleep outputs are low and `in_ready` is high.
- R3: The high domain is needed only when both operands have a nonzero upper 16 bits; the middle domain is needed when at least one operand has a nonzero upper 16 bits. So when both upper halves are zero, both domains may sleep; when exactly one is zero, only the high domain may sleep.
- R4: An awake domain raises its sleep output at the IDLE_CYCLES-th consecutive rising edge at which no valid request needing it is presented (4 by default), and not earlier.
- R5: When a valid request needs a sleeping domain, that domain's sleep output falls at the next edge and `in_ready` stays low until the domain has spent WAKE_CYCLES cycles waking (3 by default), giving WAKE_CYCLES+1 low-ready cycles counted from the cycle the request appears.
- R6: The middle domain is never asleep while the high domain is not asleep (`sleep_m` high implies `sleep_h` high).
- R7: A request that needs no sleeping domain is accepted in the cycle it is presented and leaves the sleep outputs unchanged.
- R8: The product is exact in all three modes (none asleep, high asleep, both asleep), since a sleeping or waking domain contributes zero.
- R9: A valid request needing an awake domain restarts that domain's idle count, so gaps shorter than IDLE_CYCLES never put it to sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present on the operand inputs |
| in_ready | output | 1 | Request can be accepted this cycle |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| out_valid | output | 1 | One-cycle pulse marking a new product |
| product | output | 64 | Registered unsigned product |
| sleep_h | output | 1 | High domain (upper x upper) switched off |
| sleep_m | output | 1 | Middle domain (cross terms) switched off |

## Verification
A domain controller stuck in the wrong state shows at the ports within one or two cycles: a domain believed awake while off corrupts bits 16 and above of the very next product that needs it, and a domain believed off while needed drops `in_ready` with no matching fall of its sleep output. An idle counter off by one moves the sleep edge by one cycle, which the bench catches by sampling the sleep outputs on both sides of the expected edge. A wrong wake count stretches or shortens the number of low-ready cycles seen by a request, which the bench counts exactly.

// File: rtl/opgate_mul_pkg.sv
package opgate_mul_pkg;

   typedef enum logic [1:0] {
      DOM_ON   = 2'd0,
      DOM_OFF  = 2'd1,
      DOM_WAKE = 2'd2
   } dom_state_t;

   // partial-product section kinds
   localparam int unsigned SEC_LOW  = 0;
   localparam int unsigned SEC_MID  = 1;
   localparam int unsigned SEC_HIGH = 2;

endpackage

// File: rtl/opgate_zero_det.sv
module opgate_zero_det #(
   parameter int unsigned OP_W = 32
) (
   input  logic [OP_W-1:0] op_i,
   output logic            up_zero_o
);
   localparam int unsigned HALF_W = OP_W / 2;

   assign up_zero_o = ~|op_i[OP_W-1:HALF_W];
endmodule

// File: rtl/opgate_part_mul.sv
module opgate_part_mul #(
   parameter int unsigned OP_W = 32,
   parameter int unsigned KIND = 0
) (
   input  logic [OP_W-1:0]   a_i,
   input  logic [OP_W-1:0]   b_i,
   input  logic              en_i,
   output logic [OP_W:0]     part_o
);
   import opgate_mul_pkg::*;

   localparam int unsigned HALF_W = OP_W / 2;
   localparam int unsigned PART_W = OP_W + 1;

   logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
   logic [PART_W-1:0] raw;

   assign a_lo = a_i[HALF_W-1:0];
   assign a_hi = a_i[OP_W-1:HALF_W];
   assign b_lo = b_i[HALF_W-1:0];
   assign b_hi = b_i[OP_W-1:HALF_W];

   generate
      if (KIND == SEC_LOW) begin : g_low
         assign raw = PART_W'(a_lo) * PART_W'(b_lo);
      end else if (KIND == SEC_MID) begin : g_mid
         assign raw = PART_W'(a_hi) * PART_W'(b_lo) + PART_W'(a_lo) * PART_W'(b_hi);
      end else if (KIND == SEC_HIGH) begin : g_high
         assign raw = PART_W'(a_hi) * PART_W'(b_hi);
      end else begin : g_bad_kind
         $error("opgate_part_mul: unknown section kind");
         assign raw = '0;
      end
   endgenerate

   // an unpowered section reads as zero
   assign part_o = en_i ? raw : '0;
endmodule

// File: rtl/opgate_domain_ctl.sv
module opgate_domain_ctl #(
   parameter int unsigned IDLE_CYCLES = 4,
   parameter int unsigned WAKE_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic sleep_o,
   output logic awake_o
);
   import opgate_mul_pkg::*;

   localparam int unsigned CNT_MAX = (IDLE_CYCLES > WAKE_CYCLES) ? IDLE_CYCLES : WAKE_CYCLES;
   localparam int unsigned CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYCLES - 1);
   localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

   generate
      if (IDLE_CYCLES < 1) begin : g_bad_idle
         $error("opgate_domain_ctl: IDLE_CYCLES must be at least 1");
      end
      if (WAKE_CYCLES < 1) begin : g_bad_wake
         $error("opgate_domain_ctl: WAKE_CYCLES must be at least 1");
      end
   endgenerate

   dom_state_t    state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= DOM_ON;
         cnt   <= '0;
      end else begin
         case (state)
            DOM_ON: begin
               if (req_i) begin
                  cnt <= '0;
               end else if (cnt == IDLE_LAST) begin
                  state <= DOM_OFF;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            DOM_OFF: begin
               if (req_i) begin
                  state <= DOM_WAKE;
                  cnt   <= '0;
               end
            end
            DOM_WAKE: begin
               if (cnt == WAKE_LAST) begin
                  state <= DOM_ON;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= DOM_ON;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign sleep_o = (state == DOM_OFF);
   assign awake_o = (state == DOM_ON);

   // R5: leaving sleep never makes the domain usable in the same cycle
   assert_wake_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_o) |-> !awake_o);

   // R4: sleep is entered only after a cycle without a request
   assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> $past(!req_i));
endmodule

// File: rtl/opgate_mul.sv
module opgate_mul #(
   parameter int unsigned OP_W        = 32,
   parameter int unsigned IDLE_CYCLES = 4,
   parameter int unsigned WAKE_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic              out_valid,
   output logic [2*OP_W-1:0] product,
   output logic              sleep_h,
   output logic              sleep_m
);
   import opgate_mul_pkg::*;

   localparam int unsigned HALF_W = OP_W / 2;
   localparam int unsigned PROD_W = 2 * OP_W;
   localparam int unsigned NSEC   = 3;

   generate
      if (OP_W < 4 || (OP_W % 2) != 0) begin : g_bad_width
         $error("opgate_mul: OP_W must be even and at least 4");
      end
   endgenerate

   logic a_up_zero, b_up_zero;
   logic need_h, need_m, accept;
   logic awake_h, awake_m;
   logic [NSEC-1:0] sec_en;
   logic [OP_W:0]   part [NSEC];
   logic [PROD_W-1:0] sum;

   opgate_zero_det #(.OP_W(OP_W)) i_zd_a (.op_i(op_a), .up_zero_o(a_up_zero));
   opgate_zero_det #(.OP_W(OP_W)) i_zd_b (.op_i(op_b), .up_zero_o(b_up_zero));

   // high section: both upper halves nonzero; middle: any upper half nonzero
   assign need_h = !a_up_zero && !b_up_zero;
   assign need_m = !(a_up_zero && b_up_zero);

   opgate_domain_ctl #(.IDLE_CYCLES(IDLE_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) i_ctl_h (
      .clk(clk), .rst_n(rst_n), .req_i(in_valid && need_h),
      .sleep_o(sleep_h), .awake_o(awake_h));

   opgate_domain_ctl #(.IDLE_CYCLES(IDLE_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) i_ctl_m (
      .clk(clk), .rst_n(rst_n), .req_i(in_valid && need_m),
      .sleep_o(sleep_m), .awake_o(awake_m));

   assign in_ready = (!need_h || awake_h) && (!need_m || awake_m);
   assign accept   = in_valid && in_ready;

   assign sec_en[SEC_LOW]  = 1'b1;
   assign sec_en[SEC_MID]  = awake_m;
   assign sec_en[SEC_HIGH] = awake_h;

   generate
      for (genvar s = 0; s < NSEC; s++) begin : g_sec
         opgate_part_mul #(.OP_W(OP_W), .KIND(s)) i_part (
            .a_i(op_a), .b_i(op_b), .en_i(sec_en[s]), .part_o(part[s]));
      end
   endgenerate

   assign sum = PROD_W'(part[SEC_LOW])
              + (PROD_W'(part[SEC_MID]) << HALF_W)
              + (PROD_W'(part[SEC_HIGH]) << OP_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         product   <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            product <= sum;
         end
      end
   end

   // R5: an accepted request never relies on a domain that is not fully on
   assert_accept_awake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && need_h) |-> (awake_h && !sleep_h));

   // R1: valid pulses only after an accepted request
   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(accept));

   // R8: result is exact whatever the power mode was
   assert_product_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (product == $past(PROD_W'(op_a) * PROD_W'(op_b))));

   // R6: middle section only sleeps when the high section sleeps too
   assert_mode_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_m |-> sleep_h);
endmodule

// File: tb/test_opgate_mul.sv
`timescale 1ns/1ps
module test_opgate_mul;

   localparam int unsigned OP_W  = 32;
   localparam int unsigned IDLE  = 4;
   localparam int unsigned WAKE  = 3;
   localparam int unsigned NVEC  = 10;

   // stimulus pairs {op_a, op_b}; expected product is a*b (R1, R8)
   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0000_0003, 32'h0000_0005},
      {32'h0000_FFFF, 32'h0000_FFFF},
      {32'h0001_0000, 32'h0000_0007},
      {32'h0000_0007, 32'h0001_0000},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {32'h1234_5678, 32'h9ABC_DEF0},
      {32'h0000_0000, 32'hFFFF_FFFF},
      {32'h8000_0000, 32'h0000_0002},
      {32'h0000_FFFF, 32'h0001_0000},
      {32'hDEAD_BEEF, 32'h0000_1234}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [OP_W-1:0]   op_a = '0;
   logic [OP_W-1:0]   op_b = '0;
   logic              out_valid;
   logic [2*OP_W-1:0] product;
   logic              sleep_h, sleep_m;

   int checks = 0;
   int errors = 0;
   int waits  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   opgate_mul #(.OP_W(OP_W), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)) i_opgate_mul (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product),
      .sleep_h(sleep_h), .sleep_m(sleep_m));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n    = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive at a negedge, wait for ready, check the result one edge after acceptance
   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
      op_a     = a;
      op_b     = b;
      in_valid = 1'b1;
      waits    = 0;
      #0.1;
      while (!in_ready) begin
         waits++;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, 64'(out_valid), 64'd1);
      check({req, " product"}, product, 64'(a) * 64'(b));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R2: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2 valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      #0.1;
      check("R2 sleep after reset", {62'd0, sleep_h, sleep_m}, 64'd0);
      check("R2 ready after reset", 64'(in_ready), 64'd1);

      // vector table (R1, R8): mixed modes, exact product every time
      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][63:32], VEC[i][31:0], "R1");
      end
      @(negedge clk);
      check("R2 no pulse when idle", 64'(out_valid), 64'd0);

      // R4: sleep rises exactly at the IDLE-th idle edge
      do_reset();
      repeat (IDLE - 1) @(posedge clk);
      @(negedge clk);
      check("R4 not yet asleep", {62'd0, sleep_h, sleep_m}, 64'd0);
      @(negedge clk);
      check("R4 both asleep", {62'd0, sleep_h, sleep_m}, 64'd3);

      // R7/R8: small operands need no domain; both stay asleep
      run_op(32'h0000_ABCD, 32'h0000_1234, "R8 both asleep");
      check("R7 no wait", 64'(waits), 64'd0);
      check("R7 sleep kept", {62'd0, sleep_h, sleep_m}, 64'd3);

      // R5/R3: one upper half nonzero wakes only the middle domain
      run_op(32'h0003_0001, 32'h0000_0009, "R8 high asleep");
      check("R5 middle wake wait", 64'(waits), 64'(WAKE + 1));
      check("R3 only high asleep", {62'd0, sleep_h, sleep_m}, 64'd2);

      // R5: both upper halves nonzero wakes the high domain
      run_op(32'h0002_0005, 32'h0007_0003, "R8 none asleep");
      check("R5 high wake wait", 64'(waits), 64'(WAKE + 1));
      check("R5 both awake", {62'd0, sleep_h, sleep_m}, 64'd0);

      // R9: a gap shorter than IDLE keeps the domain on
      repeat (IDLE - 2) @(negedge clk);
      run_op(32'hFFFF_0000, 32'h0001_0001, "R9");
      check("R9 no wait", 64'(waits), 64'd0);
      check("R9 still awake", {62'd0, sleep_h, sleep_m}, 64'd0);

      // R3/R6: steady traffic with one zero upper half sleeps only the high domain
      for (int k = 0; k < IDLE + 2; k++) begin
         run_op(32'h0040_0000 + k, 32'h0000_0100, "R3 stream");
      end
      check("R3 high asleep middle on", {62'd0, sleep_h, sleep_m}, 64'd2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule